// File: doc/BRIEF.md
# Per-Line Programmable Debounce Filter

This block cleans up slow, noisy external interrupt pins before they reach an interrupt controller. Each pin first goes through a two-stage synchronizer. For the lower-numbered lines that can be debounced, a stability counter then decides when the filtered level may follow the pin. A new level is accepted only once the pin has held it for a chosen number of time-base ticks. A free-running prescaler produces one tick every `TICK_DIV` clock cycles, and one tick stands for 500 µs of wall time.

Software sets up each debounce-capable line through an 8-bit control byte. The bytes are packed four to a 32-bit word and reached through three address windows: one to read, one where written ones set bits, and one where written ones clear bits. The byte holds an enable bit, a self-timed counter restart bit and a 3-bit time-select code. A line is filtered only when its byte is enabled and the line is set to level sensitivity. In every other case the synchronized pin passes straight through.

Top module: `line_debounce_filter`

## Requirements
- R1: After reset every `pinFilt` bit is 0 and every control byte reads 0.
- R2: Reads at word address 0x500 + 4*w return the control bytes, with line i in byte lane i mod 4 (bits 8*(i mod 4)+7 .. 8*(i mod 4)) of word i/4. In each byte, bit 0 is enable and bits 6:4 are the time-select code. Bits 1, 2, 3 and 7 read 0. Writes to the 0x500 window have no effect.
- R3: A write to 0x600 + 4*w sets every enable or code bit that is written as 1 and leaves bits written as 0 unchanged. The result is visible on the next read.
- R4: A write to 0x700 + 4*w clears every enable or code bit that is written as 1 and leaves the other bits unchanged.
- R5: Writing 1 to bit 1 of a line's byte through the 0x600 window restarts that line's stability counter no later than the second clock edge after the write. The bit always reads back as 0.
- R6: Codes 0..6 require 1, 2, 32, 64, 128, 256 and 512 ticks of stability (500 µs to 256 ms). After a pin change, `pinFilt` still shows the old level (code ticks − 1)·TICK_DIV cycles later and shows the new level by (code ticks)·TICK_DIV + 3 cycles.
- R7: Code 7 requires the same 512 ticks as code 6.
- R8: A pin pulse shorter than the selected stable time never reaches `pinFilt`.
- R9: A line whose enable bit is 0 has `pinFilt` follow the pin within 3 clock edges.
- R10: A line whose `lvlSens` bit is 0 has `pinFilt` follow the pin within 3 clock edges, whatever its control byte holds.
- R11: Lines at or above `DB_LINES` have no control byte: their lanes read 0, writes to them are ignored, and their `pinFilt` follows the pin within 3 clock edges.
- R12: On a filtered line, `pinFilt` changes only on a clock edge at which the time-base tick is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address: bits 11:8 pick the window, bits 7:2 pick the word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| lvlSens | input | NUM_LINES | 1 = line is level sensitive, so filtering is allowed |
| pinRaw | input | NUM_LINES | Asynchronous external pins |
| pinFilt | output | NUM_LINES | Synchronized and filtered levels |

## Verification
Register reads are combinational, so each write is checked on the very next read, one cycle later. Pass-through lines pass through three registers, and the bench samples them four cycles after a pin change. On filtered lines the tick phase is unknown, so every timing check uses two samples. The first comes (ticks − 1)·TICK_DIV cycles after the change and must still show the old level. The second comes at ticks·TICK_DIV + 3 and must show the new level. For the restart test, the bench counts both samples from the write cycle and allows one extra cycle for the registered restart strobe.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  localparam int CNT_W = 10;

  localparam logic [3:0] VIEW_READ = 4'h5;
  localparam logic [3:0] VIEW_SET  = 4'h6;
  localparam logic [3:0] VIEW_CLR  = 4'h7;

  localparam int BIT_EN   = 0;
  localparam int BIT_RST  = 1;
  localparam int BIT_SEL  = 4;

  typedef struct packed {
    logic       en;
    logic [2:0] sel;
    logic       restart;
  } lineCtl_t;

  // stable time in 500 us ticks; code 7 repeats the longest setting
  function automatic logic [CNT_W-1:0] stableTicks(input logic [2:0] sel);
    case (sel)
      3'd0:    stableTicks = CNT_W'(1);
      3'd1:    stableTicks = CNT_W'(2);
      3'd2:    stableTicks = CNT_W'(32);
      3'd3:    stableTicks = CNT_W'(64);
      3'd4:    stableTicks = CNT_W'(128);
      3'd5:    stableTicks = CNT_W'(256);
      default: stableTicks = CNT_W'(512);
    endcase
  endfunction

endpackage

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int DB_LINES = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWe,
  input  logic [11:0]                    regAddr,
  input  logic [31:0]                    regWdata,
  output logic [31:0]                    regRdata,
  output lineCtl_t [DB_LINES-1:0]        lineCtl
);

  localparam int NUM_WORDS = (DB_LINES + 3) / 4;

  logic [3:0] view;
  logic [5:0] wordSel;
  logic [DB_LINES-1:0]      enVec;
  logic [DB_LINES-1:0][2:0] selVec;

  assign view    = regAddr[11:8];
  assign wordSel = regAddr[7:2];

  for (genvar i = 0; i < DB_LINES; i++) begin : g_field
    localparam int WORD = i / 4;
    localparam int LANE = (i % 4) * 8;

    logic       hitSet, hitClr;
    logic       enQ, rstQ;
    logic [2:0] selQ;

    assign hitSet = regWe && (view == VIEW_SET) && (wordSel == 6'(WORD));
    assign hitClr = regWe && (view == VIEW_CLR) && (wordSel == 6'(WORD));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ  <= 1'b0;
        selQ <= 3'd0;
        rstQ <= 1'b0;
      end else begin
        rstQ <= hitSet && regWdata[LANE + BIT_RST];
        if (hitSet) begin
          enQ  <= enQ  | regWdata[LANE + BIT_EN];
          selQ <= selQ | regWdata[LANE + BIT_SEL +: 3];
        end else if (hitClr) begin
          enQ  <= enQ  & ~regWdata[LANE + BIT_EN];
          selQ <= selQ & ~regWdata[LANE + BIT_SEL +: 3];
        end
      end
    end

    assign enVec[i]  = enQ;
    assign selVec[i] = selQ;
    assign lineCtl[i] = '{en: enQ, sel: selQ, restart: rstQ};
  end

  always_comb begin
    regRdata = '0;
    if (view == VIEW_READ && int'(wordSel) < NUM_WORDS) begin
      for (int i = 0; i < DB_LINES; i++) begin
        if (wordSel == 6'(i / 4)) begin
          regRdata[(i % 4) * 8 +: 8] = {1'b0, selVec[i], 3'b000, enVec[i]};
        end
      end
    end
  end

endmodule

// File: rtl/dbf_datapath.sv
module dbf_datapath
  import dbf_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DB_LINES  = 6,
  parameter int TICK_DIV  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lineCtl_t [DB_LINES-1:0] lineCtl,
  input  logic [NUM_LINES-1:0]    lvlSens,
  input  logic [NUM_LINES-1:0]    pinRaw,
  output logic [NUM_LINES-1:0]    pinFilt,
  output logic                    tick
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  // time base
  if (TICK_DIV > 1) begin : g_div
    logic [DIV_W-1:0] divCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               divCnt <= '0;
      else if (divCnt == DIV_W'(TICK_DIV - 1)) divCnt <= '0;
      else                                     divCnt <= divCnt + 1'b1;
    end
    assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  // two-stage synchronizer
  logic [NUM_LINES-1:0] metaQ, syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= pinRaw;
      syncQ <= metaQ;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic filtQ;
    if (i < DB_LINES) begin : g_filt
      logic             active;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] limit;

      assign active = lineCtl[i].en && lvlSens[i];
      assign limit  = stableTicks(lineCtl[i].sel);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt   <= '0;
          filtQ <= 1'b0;
        end else if (!active) begin
          cnt   <= '0;
          filtQ <= syncQ[i];
        end else if (lineCtl[i].restart) begin
          cnt   <= '0;
        end else if (syncQ[i] == filtQ) begin
          cnt   <= '0;
        end else if (tick) begin
          if ((cnt + CNT_W'(1)) >= limit) begin
            cnt   <= '0;
            filtQ <= syncQ[i];
          end else begin
            cnt   <= cnt + CNT_W'(1);
          end
        end
      end
    end else begin : g_pass
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) filtQ <= 1'b0;
        else       filtQ <= syncQ[i];
      end
    end
    assign pinFilt[i] = filtQ;
  end

endmodule

// File: rtl/line_debounce_filter.sv
module line_debounce_filter
  import dbf_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DB_LINES  = 6,
  parameter int TICK_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [11:0]          regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic [NUM_LINES-1:0] lvlSens,
  input  logic [NUM_LINES-1:0] pinRaw,
  output logic [NUM_LINES-1:0] pinFilt
);

  lineCtl_t [DB_LINES-1:0] lineCtl;
  logic                    tick;

  dbf_ctrl #(.DB_LINES(DB_LINES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .lineCtl  (lineCtl)
  );

  dbf_datapath #(
    .NUM_LINES (NUM_LINES),
    .DB_LINES  (DB_LINES),
    .TICK_DIV  (TICK_DIV)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .lineCtl (lineCtl),
    .lvlSens (lvlSens),
    .pinRaw  (pinRaw),
    .pinFilt (pinFilt),
    .tick    (tick)
  );

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker
  import dbf_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DB_LINES  = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWe,
  input logic [11:0]             regAddr,
  input logic [31:0]             regWdata,
  input logic [NUM_LINES-1:0]    lvlSens,
  input logic [NUM_LINES-1:0]    pinFilt,
  input lineCtl_t [DB_LINES-1:0] lineCtl,
  input logic                    tick
);

  logic word0Set, word0Clr;
  assign word0Set = regWe && regAddr[11:8] == VIEW_SET && regAddr[7:2] == 6'd0;
  assign word0Clr = regWe && regAddr[11:8] == VIEW_CLR && regAddr[7:2] == 6'd0;

  a_r3_set_enable: assert property (@(posedge clk) disable iff (!rstN)
    (word0Set && regWdata[BIT_EN]) |=> lineCtl[0].en);

  a_r4_clear_enable: assert property (@(posedge clk) disable iff (!rstN)
    (word0Clr && regWdata[BIT_EN]) |=> !lineCtl[0].en);

  a_r5_restart_origin: assert property (@(posedge clk) disable iff (!rstN)
    lineCtl[0].restart |-> $past(word0Set && regWdata[BIT_RST]));

  a_r12_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (pinFilt[0] != $past(pinFilt[0]) && $past(lineCtl[0].en) && $past(lvlSens[0]))
      |-> $past(tick));

endmodule

bind line_debounce_filter dbf_checker #(
  .NUM_LINES (NUM_LINES),
  .DB_LINES  (DB_LINES)
) i_dbf_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .lvlSens  (lvlSens),
  .pinFilt  (pinFilt),
  .lineCtl  (lineCtl),
  .tick     (tick)
);

// File: tb/test_line_debounce_filter.sv
module test_line_debounce_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_LINES  = 8;
  localparam int DB_LINES   = 6;
  localparam int TICK_DIV   = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regWe = 1'b0;
  logic [11:0]          regAddr = '0;
  logic [31:0]          regWdata = '0;
  logic [31:0]          regRdata;
  logic [NUM_LINES-1:0] lvlSens = '1;
  logic [NUM_LINES-1:0] pinRaw = '0;
  logic [NUM_LINES-1:0] pinFilt;

  int totalCnt = 0;
  int failCnt  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_debounce_filter #(
    .NUM_LINES (NUM_LINES),
    .DB_LINES  (DB_LINES),
    .TICK_DIV  (TICK_DIV)
  ) i_line_debounce_filter (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .lvlSens  (lvlSens),
    .pinRaw   (pinRaw),
    .pinFilt  (pinFilt)
  );

  typedef struct packed {
    logic        isRead;
    logic [11:0] addr;
    logic [31:0] data;
  } regOp_t;

  localparam int N_OPS = 16;
  localparam regOp_t OPS [N_OPS] = '{
    '{1'b0, 12'h600, 32'h0000_0031},
    '{1'b1, 12'h500, 32'h0000_0031},
    '{1'b0, 12'h600, 32'h0052_0000},
    '{1'b1, 12'h500, 32'h0050_0031},
    '{1'b0, 12'h700, 32'h0000_0030},
    '{1'b1, 12'h500, 32'h0050_0001},
    '{1'b0, 12'h604, 32'hFFFF_FFFF},
    '{1'b1, 12'h504, 32'h0000_7171},
    '{1'b0, 12'h704, 32'h0000_0100},
    '{1'b1, 12'h504, 32'h0000_7071},
    '{1'b0, 12'h500, 32'hFFFF_FFFF},
    '{1'b1, 12'h500, 32'h0050_0001},
    '{1'b0, 12'h700, 32'hFFFF_FFFF},
    '{1'b0, 12'h704, 32'hFFFF_FFFF},
    '{1'b1, 12'h500, 32'h0000_0000},
    '{1'b1, 12'h504, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr  = a;
    regWdata = d;
    regWe    = 1'b1;
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    check("R1 pinFilt", 32'(pinFilt), 32'h0);
    regRead(12'h500, rd);
    check("R1 word0", rd, 32'h0);
    regRead(12'h504, rd);
    check("R1 word1", rd, 32'h0);

    // R2 R3 R4 R5 R11 register views, table driven
    for (int k = 0; k < N_OPS; k++) begin
      @(negedge clk);
      if (OPS[k].isRead) begin
        regRead(OPS[k].addr, rd);
        check($sformatf("R2 R3 R4 R11 op%0d", k), rd, OPS[k].data);
      end else begin
        regWrite(OPS[k].addr, OPS[k].data);
      end
    end

    // R6 code 1: two ticks
    regWrite(12'h600, 32'h11);
    pinRaw[0] = 1'b1;
    waitCyc(1 * TICK_DIV);
    check("R6 code1 rise old", 32'(pinFilt[0]), 32'h0);
    waitCyc(TICK_DIV + 3);
    check("R6 code1 rise new", 32'(pinFilt[0]), 32'h1);
    pinRaw[0] = 1'b0;
    waitCyc(1 * TICK_DIV);
    check("R6 code1 fall old", 32'(pinFilt[0]), 32'h1);
    waitCyc(TICK_DIV + 3);
    check("R6 code1 fall new", 32'(pinFilt[0]), 32'h0);

    // R6 code 0: one tick
    regWrite(12'h700, 32'h10);
    pinRaw[0] = 1'b1;
    waitCyc(1);
    check("R6 code0 old", 32'(pinFilt[0]), 32'h0);
    waitCyc(TICK_DIV + 2);
    check("R6 code0 new", 32'(pinFilt[0]), 32'h1);
    pinRaw[0] = 1'b0;
    waitCyc(TICK_DIV + 3);
    check("R6 code0 back", 32'(pinFilt[0]), 32'h0);

    // R7 code 7 acts as 512 ticks
    regWrite(12'h600, 32'h70);
    pinRaw[0] = 1'b1;
    waitCyc(511 * TICK_DIV);
    check("R7 code7 old", 32'(pinFilt[0]), 32'h0);
    waitCyc(TICK_DIV + 3);
    check("R7 code7 new", 32'(pinFilt[0]), 32'h1);

    // R9 disabled line passes through
    regWrite(12'h700, 32'h71);
    pinRaw[0] = 1'b0;
    waitCyc(4);
    check("R9 follow low", 32'(pinFilt[0]), 32'h0);
    pinRaw[0] = 1'b1;
    waitCyc(4);
    check("R9 follow high", 32'(pinFilt[0]), 32'h1);
    pinRaw[0] = 1'b0;
    waitCyc(4);
    check("R9 follow low again", 32'(pinFilt[0]), 32'h0);

    // R8 short glitch with code 2 (32 ticks)
    regWrite(12'h600, 32'h21);
    pinRaw[0] = 1'b1;
    waitCyc(40);
    pinRaw[0] = 1'b0;
    check("R8 glitch during", 32'(pinFilt[0]), 32'h0);
    waitCyc(200);
    check("R8 glitch after", 32'(pinFilt[0]), 32'h0);

    // R5 restart delays acceptance
    pinRaw[0] = 1'b1;
    waitCyc(100);
    regWrite(12'h600, 32'h02);
    waitCyc(100);
    check("R5 restart held old", 32'(pinFilt[0]), 32'h0);
    waitCyc(35);
    check("R5 restart then new", 32'(pinFilt[0]), 32'h1);
    regRead(12'h500, rd);
    check("R5 restart bit reads 0", rd, 32'h21);

    // R10 edge-type line bypasses the filter
    lvlSens[0] = 1'b0;
    pinRaw[0] = 1'b0;
    waitCyc(4);
    check("R10 bypass", 32'(pinFilt[0]), 32'h0);

    // R11 line without a control byte
    pinRaw[6] = 1'b1;
    waitCyc(4);
    check("R11 line6 follow", 32'(pinFilt[6]), 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule